// File: doc/BRIEF.md
# Scan-Protected Cipher Register Bank

This block is the software-visible register bank for a 128-bit block cipher engine. A simple bus (enable, write select, word address and 32-bit data) loads the cipher key and the two input blocks (one to encrypt, one to decrypt), sets three start flags, and reads back every stored value. The engine itself sits outside. It reports through plain inputs: a 128-bit result and a done strobe for each direction, plus a key-done strobe. The bank captures these results and flags into its own storage.

Every storage bit of the bank is also one stage of a single serial test chain. While the scan enable is high, the chain shifts by one stage per clock and the bus and the engine are locked out. The chain visits the registers in a fixed order that does not follow the address map. Inverters sit at the inputs of chosen stages, and a parameter mask selects those stages. As a result, the bit stream seen on the serial output differs from the stored contents, and only the holder of the mask can interpret it. The inverters lie only on the shift path, so bus reads and writes return the true values.

Top module: `cryptoRegBank`

## Requirements
- R1: After reset every storage bit is 0. Every bus read returns 0, all start outputs are 0, and scanOut is 0.
- R2: Bus writes go into the key at addresses 0-3, the cipher input at 4-7 and the decrypt input at 12-15. Within each group the lowest address holds the least significant word. A write to one of these addresses takes effect at the clock edge, and a later read of the same address returns the written word.
- R3: Addresses 8-11 read the stored cipher result and 16-19 read the stored decrypt result, least significant word first. The bank copies cipherResult into this storage on each clock where cipherDoneIn is high and scanEn is low, and copies decryptResult on each clock where decryptDoneIn is high and scanEn is low. Bus writes to these addresses have no effect.
- R4: Address 20 reads as follows: bit0 start-key, bit1 start-cipher, bit2 start-decrypt, bit3 key-done, bit4 cipher-done, bit5 decrypt-done. Bits 31-6 read 0. A write to this address loads the three start flags from busWdata[2:0]. On every clock with scanEn low, the three done bits take the value of keyDoneIn, cipherDoneIn and decryptDoneIn.
- R5: Addresses 21-31 read as 0, and writes to them change nothing.
- R6: While scanEn is high, bus writes and engine results are ignored and no done flag is captured. Storage changes only by shifting.
- R7: With scanEn high, each clock moves every chain stage one position toward scanOut. scanOut shows stage 0. The stages, counted from scanOut, are: 0 key-done, 1 cipher-done, 2 decrypt-done, 3 start-key, 4 start-cipher, 5 start-decrypt, 6-133 decrypt result bits 0-127, 134-261 cipher result, 390-517 cipher input, 518-645 key. Stages 262-389 hold the decrypt input. scanIn enters at stage 645, which is key bit 127.
- R8: INV_MASK bit i puts an inverter at the input of stage i. A value that moves into stage i, from stage i+1 or from scanIn at the top stage, is complemented when INV_MASK bit i is 1. Bus reads, bus writes and engine captures do not pass through the inverters.
- R9: keyOut, cipherSrcOut and decryptSrcOut always show the stored key, cipher input and decrypt input. startKeyOut, startCipherOut and startDecryptOut show the three start flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busEn | input | 1 | Bus access enable |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational; 0 when not reading |
| cipherResult | input | 128 | Encrypted block from the engine |
| decryptResult | input | 128 | Decrypted block from the engine |
| keyDoneIn | input | 1 | Engine key expansion done |
| cipherDoneIn | input | 1 | Engine encryption done |
| decryptDoneIn | input | 1 | Engine decryption done |
| keyOut | output | 128 | Stored key |
| cipherSrcOut | output | 128 | Stored block to encrypt |
| decryptSrcOut | output | 128 | Stored block to decrypt |
| startKeyOut | output | 1 | Start key expansion flag |
| startCipherOut | output | 1 | Start encryption flag |
| startDecryptOut | output | 1 | Start decryption flag |
| scanEn | input | 1 | Scan shift enable |
| scanIn | input | 1 | Serial chain input |
| scanOut | output | 1 | Serial chain output (stage 0) |

## Verification
The bound checker watches several behaviours on every clock. It checks the shift along the key segment and the inversion at its entry stage, and the start flags moving down the chain even when a write is attempted during a shift. It also checks the result of writes to key word 0 and to the start flags, and the zero upper bits and out-of-range reads. Other behaviours appear only in the bench's scenarios, because each one needs a whole sequence of cycles. These are the capture of engine results and their write protection, and the full 646-stage scan-out against a model that includes the mask parity. They also include the scan-in of a pattern whose readback over the bus must show the complement set by the mask.

// File: rtl/cregPkg.sv
package cregPkg;
  localparam int IDX_W = 4;
  localparam int FLAG_STAGES = 6;

  typedef enum logic [2:0] {
    RD_NONE, RD_KEY, RD_CIN, RD_COUT, RD_DIN, RD_DOUT, RD_CTRL
  } rdSel_e;

  typedef struct packed {
    logic             shift;
    logic             wrKey;
    logic             wrCin;
    logic             wrDin;
    logic             wrCtrl;
    logic             ldCout;
    logic             ldDout;
    logic             capDone;
    logic [IDX_W-1:0] wordIdx;
    rdSel_e           rdSel;
  } cregStrobe_t;
endpackage

// File: rtl/cregControl.sv
module cregControl
  import cregPkg::*;
#(
  parameter int BLK_WORDS = 4,
  parameter int ADDR_W    = 5
) (
  input  logic              busEn,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              scanEn,
  input  logic              cipherDoneIn,
  input  logic              decryptDoneIn,
  output cregStrobe_t       stb
);
  localparam int DATA_WORDS = 5 * BLK_WORDS;
  localparam int CTRL_ADDR  = DATA_WORDS;

  int  addrNum;
  int  bankNum;
  logic wrOk;
  logic rdOk;

  always_comb begin
    addrNum = int'(busAddr);
    bankNum = addrNum / BLK_WORDS;
    wrOk    = busEn && busWrite && !scanEn;
    rdOk    = busEn && !busWrite;

    stb         = '0;
    stb.rdSel   = RD_NONE;
    stb.shift   = scanEn;
    stb.capDone = !scanEn;
    stb.ldCout  = !scanEn && cipherDoneIn;
    stb.ldDout  = !scanEn && decryptDoneIn;
    stb.wordIdx = IDX_W'(addrNum % BLK_WORDS);

    if (addrNum < DATA_WORDS) begin
      case (bankNum)
        0: begin
          stb.wrKey = wrOk;
          if (rdOk) stb.rdSel = RD_KEY;
        end
        1: begin
          stb.wrCin = wrOk;
          if (rdOk) stb.rdSel = RD_CIN;
        end
        2: if (rdOk) stb.rdSel = RD_COUT;
        3: begin
          stb.wrDin = wrOk;
          if (rdOk) stb.rdSel = RD_DIN;
        end
        default: if (rdOk) stb.rdSel = RD_DOUT;
      endcase
    end else if (addrNum == CTRL_ADDR) begin
      stb.wrCtrl = wrOk;
      if (rdOk) stb.rdSel = RD_CTRL;
    end
  end
endmodule

// File: rtl/cregDatapath.sv
module cregDatapath
  import cregPkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int BLK_WORDS = 4,
  parameter int BLK_W     = WORD_W * BLK_WORDS,
  parameter int CHAIN_LEN = 5 * BLK_W + FLAG_STAGES,
  parameter logic [CHAIN_LEN-1:0] INV_MASK = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  cregStrobe_t       stb,
  input  logic [WORD_W-1:0] wdata,
  input  logic [BLK_W-1:0]  cipherResult,
  input  logic [BLK_W-1:0]  decryptResult,
  input  logic              keyDoneIn,
  input  logic              cipherDoneIn,
  input  logic              decryptDoneIn,
  input  logic              scanIn,
  output logic              scanOut,
  output logic [WORD_W-1:0] rdata,
  output logic [BLK_W-1:0]  keyOut,
  output logic [BLK_W-1:0]  cipherSrcOut,
  output logic [BLK_W-1:0]  decryptSrcOut,
  output logic              startKeyOut,
  output logic              startCipherOut,
  output logic              startDecryptOut
);
  // Chain stage offsets, counted from scanOut
  localparam int DOUT_LO  = FLAG_STAGES;
  localparam int COUT_LO  = DOUT_LO + BLK_W;
  localparam int DIN_LO   = COUT_LO + BLK_W;
  localparam int CIN_LO   = DIN_LO + BLK_W;
  localparam int KEY_LO   = CIN_LO + BLK_W;
  localparam int ST_KEY   = 3;
  localparam int ST_CIPH  = 4;
  localparam int ST_DEC   = 5;

  logic [CHAIN_LEN-1:0] chainQ;
  logic [CHAIN_LEN-1:0] chainD;
  logic [CHAIN_LEN-1:0] shiftVec;

  // Shift path: an inverter sits at each stage input selected by the mask
  for (genvar i = 0; i < CHAIN_LEN; i++) begin : gStage
    logic srcBit;
    if (i == CHAIN_LEN - 1) begin : gTop
      assign srcBit = scanIn;
    end else begin : gMid
      assign srcBit = chainQ[i+1];
    end
    if (INV_MASK[i]) begin : gInv
      assign shiftVec[i] = ~srcBit;
    end else begin : gPass
      assign shiftVec[i] = srcBit;
    end
  end

  always_comb begin
    chainD = chainQ;
    if (stb.shift) begin
      chainD = shiftVec;
    end else begin
      if (stb.wrKey) chainD[KEY_LO + int'(stb.wordIdx)*WORD_W +: WORD_W] = wdata;
      if (stb.wrCin) chainD[CIN_LO + int'(stb.wordIdx)*WORD_W +: WORD_W] = wdata;
      if (stb.wrDin) chainD[DIN_LO + int'(stb.wordIdx)*WORD_W +: WORD_W] = wdata;
      if (stb.ldCout) chainD[COUT_LO +: BLK_W] = cipherResult;
      if (stb.ldDout) chainD[DOUT_LO +: BLK_W] = decryptResult;
      if (stb.wrCtrl) begin
        chainD[ST_KEY]  = wdata[0];
        chainD[ST_CIPH] = wdata[1];
        chainD[ST_DEC]  = wdata[2];
      end
      if (stb.capDone) begin
        chainD[0] = keyDoneIn;
        chainD[1] = cipherDoneIn;
        chainD[2] = decryptDoneIn;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chainQ <= '0;
    else       chainQ <= chainD;
  end

  always_comb begin
    rdata = '0;
    case (stb.rdSel)
      RD_KEY:  rdata = chainQ[KEY_LO  + int'(stb.wordIdx)*WORD_W +: WORD_W];
      RD_CIN:  rdata = chainQ[CIN_LO  + int'(stb.wordIdx)*WORD_W +: WORD_W];
      RD_COUT: rdata = chainQ[COUT_LO + int'(stb.wordIdx)*WORD_W +: WORD_W];
      RD_DIN:  rdata = chainQ[DIN_LO  + int'(stb.wordIdx)*WORD_W +: WORD_W];
      RD_DOUT: rdata = chainQ[DOUT_LO + int'(stb.wordIdx)*WORD_W +: WORD_W];
      RD_CTRL: rdata[5:0] = {chainQ[2], chainQ[1], chainQ[0],
                             chainQ[ST_DEC], chainQ[ST_CIPH], chainQ[ST_KEY]};
      default: rdata = '0;
    endcase
  end

  assign scanOut         = chainQ[0];
  assign keyOut          = chainQ[KEY_LO +: BLK_W];
  assign cipherSrcOut    = chainQ[CIN_LO +: BLK_W];
  assign decryptSrcOut   = chainQ[DIN_LO +: BLK_W];
  assign startKeyOut     = chainQ[ST_KEY];
  assign startCipherOut  = chainQ[ST_CIPH];
  assign startDecryptOut = chainQ[ST_DEC];
endmodule

// File: rtl/cryptoRegBank.sv
module cryptoRegBank
  import cregPkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int BLK_WORDS = 4,
  parameter int ADDR_W    = 5,
  parameter logic [5*WORD_W*BLK_WORDS+FLAG_STAGES-1:0] INV_MASK =
    {{(5*WORD_W*BLK_WORDS-FLAG_STAGES){1'b0}}, 12'h4A3}
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        busEn,
  input  logic                        busWrite,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic [WORD_W-1:0]           busWdata,
  output logic [WORD_W-1:0]           busRdata,
  input  logic [WORD_W*BLK_WORDS-1:0] cipherResult,
  input  logic [WORD_W*BLK_WORDS-1:0] decryptResult,
  input  logic                        keyDoneIn,
  input  logic                        cipherDoneIn,
  input  logic                        decryptDoneIn,
  output logic [WORD_W*BLK_WORDS-1:0] keyOut,
  output logic [WORD_W*BLK_WORDS-1:0] cipherSrcOut,
  output logic [WORD_W*BLK_WORDS-1:0] decryptSrcOut,
  output logic                        startKeyOut,
  output logic                        startCipherOut,
  output logic                        startDecryptOut,
  input  logic                        scanEn,
  input  logic                        scanIn,
  output logic                        scanOut
);
  localparam int BLK_W     = WORD_W * BLK_WORDS;
  localparam int CHAIN_LEN = 5 * BLK_W + FLAG_STAGES;

  cregStrobe_t stb;

  cregControl #(.BLK_WORDS(BLK_WORDS), .ADDR_W(ADDR_W)) uCtrl (
    .busEn(busEn), .busWrite(busWrite), .busAddr(busAddr), .scanEn(scanEn),
    .cipherDoneIn(cipherDoneIn), .decryptDoneIn(decryptDoneIn), .stb(stb)
  );

  cregDatapath #(
    .WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS), .BLK_W(BLK_W),
    .CHAIN_LEN(CHAIN_LEN), .INV_MASK(INV_MASK)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWdata),
    .cipherResult(cipherResult), .decryptResult(decryptResult),
    .keyDoneIn(keyDoneIn), .cipherDoneIn(cipherDoneIn), .decryptDoneIn(decryptDoneIn),
    .scanIn(scanIn), .scanOut(scanOut), .rdata(busRdata),
    .keyOut(keyOut), .cipherSrcOut(cipherSrcOut), .decryptSrcOut(decryptSrcOut),
    .startKeyOut(startKeyOut), .startCipherOut(startCipherOut),
    .startDecryptOut(startDecryptOut)
  );
endmodule

// File: rtl/cryptoRegBankChecker.sv
module cryptoRegBankChecker #(
  parameter int WORD_W    = 32,
  parameter int BLK_WORDS = 4,
  parameter int ADDR_W    = 5,
  parameter logic [5*WORD_W*BLK_WORDS+5:0] INV_MASK = '0
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        busEn,
  input logic                        busWrite,
  input logic [ADDR_W-1:0]           busAddr,
  input logic [WORD_W-1:0]           busWdata,
  input logic [WORD_W-1:0]           busRdata,
  input logic [WORD_W*BLK_WORDS-1:0] keyOut,
  input logic                        startKeyOut,
  input logic                        startCipherOut,
  input logic                        startDecryptOut,
  input logic                        scanEn,
  input logic                        scanIn
);
  localparam int BLK_W     = WORD_W * BLK_WORDS;
  localparam int CHAIN_LEN = 5 * BLK_W + 6;
  localparam int KEY_LO    = CHAIN_LEN - BLK_W;
  localparam int CTRL_ADDR = 5 * BLK_WORDS;

  logic [BLK_W-2:0] keyMaskLow;
  assign keyMaskLow = INV_MASK[KEY_LO + BLK_W - 2 : KEY_LO];

  assert_key_word0_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!scanEn && busEn && busWrite && int'(busAddr) == 0)
      |=> keyOut[WORD_W-1:0] == $past(busWdata));

  assert_ctrl_upper_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && !busWrite && int'(busAddr) == CTRL_ADDR)
      |-> busRdata[WORD_W-1:6] == '0);

  assert_start_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!scanEn && busEn && busWrite && int'(busAddr) == CTRL_ADDR)
      |=> ({startDecryptOut, startCipherOut, startKeyOut} == $past(busWdata[2:0])));

  assert_out_of_range_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && !busWrite && int'(busAddr) > CTRL_ADDR) |-> busRdata == '0);

  assert_scan_blocks_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (scanEn && busEn && busWrite && int'(busAddr) == CTRL_ADDR)
      |=> startKeyOut == ($past(startCipherOut) ^ INV_MASK[3]));

  assert_key_shift_R7: assert property (@(posedge clk) disable iff (!rstN)
    scanEn |=> keyOut[BLK_W-2:0] == ($past(keyOut[BLK_W-1:1]) ^ keyMaskLow));

  assert_flag_shift_R7: assert property (@(posedge clk) disable iff (!rstN)
    scanEn |=> startCipherOut == ($past(startDecryptOut) ^ INV_MASK[4]));

  assert_entry_invert_R8: assert property (@(posedge clk) disable iff (!rstN)
    scanEn |=> keyOut[BLK_W-1] == ($past(scanIn) ^ INV_MASK[CHAIN_LEN-1]));
endmodule

bind cryptoRegBank cryptoRegBankChecker #(
  .WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS), .ADDR_W(ADDR_W), .INV_MASK(INV_MASK)
) uChk (
  .clk(clk), .rstN(rstN), .busEn(busEn), .busWrite(busWrite), .busAddr(busAddr),
  .busWdata(busWdata), .busRdata(busRdata), .keyOut(keyOut),
  .startKeyOut(startKeyOut), .startCipherOut(startCipherOut),
  .startDecryptOut(startDecryptOut), .scanEn(scanEn), .scanIn(scanIn)
);

// File: tb/sim_cryptoRegBank.sv
module sim_cryptoRegBank;
  localparam int L = 646;

  function automatic logic [L-1:0] makeMask();
    logic [L-1:0] m;
    m = '0;
    for (int i = 0; i < L; i++)
      if ((i % 7) == 3 || i == 0 || i == L - 1) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [L-1:0] MASK = makeMask();

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busEn = 1'b0, busWrite = 1'b0;
  logic [4:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [127:0] cipherResult = '0, decryptResult = '0;
  logic keyDoneIn = 1'b0, cipherDoneIn = 1'b0, decryptDoneIn = 1'b0;
  logic [127:0] keyOut, cipherSrcOut, decryptSrcOut;
  logic startKeyOut, startCipherOut, startDecryptOut;
  logic scanEn = 1'b0, scanIn = 1'b0;
  logic scanOut;

  int checks = 0;
  int failures = 0;

  // Bench model of contents
  logic [127:0] mKey = '0, mCin = '0, mDin = '0, mCout = '0, mDout = '0;
  logic [2:0] mStart = '0;

  always #2 clk = ~clk;

  cryptoRegBank #(.INV_MASK(MASK)) u0 (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .cipherResult(cipherResult),
    .decryptResult(decryptResult), .keyDoneIn(keyDoneIn), .cipherDoneIn(cipherDoneIn),
    .decryptDoneIn(decryptDoneIn), .keyOut(keyOut), .cipherSrcOut(cipherSrcOut),
    .decryptSrcOut(decryptSrcOut), .startKeyOut(startKeyOut),
    .startCipherOut(startCipherOut), .startDecryptOut(startDecryptOut),
    .scanEn(scanEn), .scanIn(scanIn), .scanOut(scanOut)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input int a, input logic [31:0] d);
    @(negedge clk);
    busEn = 1'b1; busWrite = 1'b1; busAddr = 5'(a); busWdata = d;
    @(posedge clk);
    #1 busEn = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input int a, output logic [31:0] d);
    @(negedge clk);
    busEn = 1'b1; busWrite = 1'b0; busAddr = 5'(a);
    #1 d = busRdata;
    busEn = 1'b0;
  endtask

  function automatic logic [31:0] modelWord(input int a);
    logic [127:0] blk;
    case (a / 4)
      0: blk = mKey;
      1: blk = mCin;
      2: blk = mCout;
      3: blk = mDin;
      default: blk = mDout;
    endcase
    return blk[(a % 4)*32 +: 32];
  endfunction

  task automatic testReset();
    logic [31:0] d;
    check("R1 scanOut", 128'(scanOut), 0);
    check("R1 keyOut", keyOut, 0);
    check("R1 starts", {startDecryptOut, startCipherOut, startKeyOut}, 0);
    for (int a = 0; a <= 20; a++) begin
      busRd(a, d);
      check($sformatf("R1 read addr %0d", a), 128'(d), 0);
    end
  endtask

  task automatic testInputWrites();
    logic [31:0] d;
    for (int a = 0; a < 20; a++) begin
      if (a / 4 == 2 || a / 4 == 4) continue;
      d = 32'h1000_0001 * (a + 3) ^ 32'hA5C3_0F96;
      busWr(a, d);
      case (a / 4)
        0: mKey[(a % 4)*32 +: 32] = d;
        1: mCin[(a % 4)*32 +: 32] = d;
        default: mDin[(a % 4)*32 +: 32] = d;
      endcase
    end
    for (int a = 0; a < 20; a++) begin
      busRd(a, d);
      check($sformatf("R2 readback addr %0d", a), 128'(d), 128'(modelWord(a)));
    end
    check("R9 keyOut", keyOut, mKey);
    check("R9 cipherSrcOut", cipherSrcOut, mCin);
    check("R9 decryptSrcOut", decryptSrcOut, mDin);
  endtask

  task automatic testResults();
    logic [31:0] d;
    @(negedge clk);
    cipherResult = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    cipherDoneIn = 1'b1;
    @(negedge clk);
    busEn = 1'b1; busWrite = 1'b0; busAddr = 5'd20;
    #1 check("R4 cipher-done bit set", 128'(busRdata), 128'h10);
    busEn = 1'b0;
    cipherDoneIn = 1'b0;
    mCout = cipherResult;
    cipherResult = '1;
    @(negedge clk);
    decryptResult = 128'hDEAD_BEEF_0BAD_F00D_1357_9BDF_2468_ACE0;
    decryptDoneIn = 1'b1; keyDoneIn = 1'b1;
    @(negedge clk);
    decryptDoneIn = 1'b0; keyDoneIn = 1'b0;
    mDout = decryptResult;
    decryptResult = '0;
    busWr(9, 32'hFFFF_FFFF);
    busWr(17, 32'h0);
    for (int a = 8; a < 20; a++) begin
      if (a >= 12 && a < 16) continue;
      busRd(a, d);
      check($sformatf("R3 result addr %0d", a), 128'(d), 128'(modelWord(a)));
    end
    busRd(20, d);
    check("R4 done bits cleared", 128'(d), 0);
  endtask

  task automatic testControl();
    logic [31:0] d;
    busWr(20, 32'hFFFF_FFFD);
    mStart = 3'b101;
    busRd(20, d);
    check("R4 ctrl read", 128'(d), 128'h5);
    check("R9 start outputs", {startDecryptOut, startCipherOut, startKeyOut}, 128'h5);
  endtask

  task automatic testOutOfRange();
    logic [31:0] d;
    busWr(21, 32'h1111_2222);
    busWr(31, 32'h3333_4444);
    busRd(21, d);
    check("R5 read addr 21", 128'(d), 0);
    busRd(31, d);
    check("R5 read addr 31", 128'(d), 0);
    busRd(0, d);
    check("R5 key word 0 untouched", 128'(d), 128'(modelWord(0)));
    check("R5 keyOut untouched", keyOut, mKey);
    busRd(20, d);
    check("R5 ctrl untouched", 128'(d), 128'(mStart));
  endtask

  // Full scan: shift out the model contents, shift in a pattern
  task automatic testScan();
    logic [L-1:0] vec, pat, after;
    logic par;
    logic [31:0] d;
    int outErr = 0;
    vec = {mKey, mCin, mDin, mCout, mDout, mStart[2], mStart[1], mStart[0], 3'b000};
    for (int t = 0; t < L; t++) pat[t] = ((t * 5 + 1) % 3 == 0) ^ (t % 11 == 0);
    par = 1'b0;
    for (int n = 0; n < L; n++) begin
      @(negedge clk);
      scanEn = 1'b1;
      scanIn = pat[n];
      // bus write and engine result while shifting must be ignored (R6)
      busEn = (n == 10); busWrite = (n == 10); busAddr = 5'd0; busWdata = 32'hFFFF_FFFF;
      cipherDoneIn = (n == 10); cipherResult = '1;
      #1;
      if (scanOut !== (vec[n] ^ par)) begin
        outErr++;
        if (outErr == 1) check($sformatf("R7 R8 scanOut bit %0d", n), 128'(scanOut), 128'(vec[n] ^ par));
      end
      par = par ^ MASK[n];
    end
    check("R7 R8 scanOut stream mismatches", 128'(outErr), 0);
    after = '0;
    par = 1'b0;
    for (int p = L - 1; p >= 0; p--) begin
      par = par ^ MASK[p];
      after[p] = pat[p] ^ par;
    end
    @(negedge clk);
    scanEn = 1'b0; busWrite = 1'b0; cipherDoneIn = 1'b0;
    busEn = 1'b1; busAddr = 5'd20;
    #1 check("R6 R8 ctrl after scan", 128'(busRdata),
             128'({after[2], after[1], after[0], after[5], after[4], after[3]}));
    busEn = 1'b0;
    mKey = after[518 +: 128]; mCin = after[390 +: 128]; mDin = after[262 +: 128];
    mCout = after[134 +: 128]; mDout = after[6 +: 128];
    for (int a = 0; a < 20; a++) begin
      busRd(a, d);
      check($sformatf("R6 R8 scanned word addr %0d", a), 128'(d), 128'(modelWord(a)));
    end
    check("R8 keyOut after scan", keyOut, mKey);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testInputWrites();
    testResults();
    testControl();
    testOutOfRange();
    testScan();
    repeat (2) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 100000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule